// File: doc/BRIEF.md
# Register Field Merge Engine

This block stands between a controller that thinks in terms of register bit fields and a slow control link to a peripheral whose registers are 16 bits wide. A field is named by a register index, a low bit position and a bit count. The controller hands over a batch of up to four such fields in one cycle. The engine turns them into one combined mask and one insert word. It then reads the register once, merges in the new bits and writes the register back once. Each access on the link is expensive, on the order of 256 serial bit times, so saving accesses matters.

The same request port also serves two other operations. A single-field write returns the value the field held before the update. A multi-field read fetches one register word and hands back every requested field from it. If a write batch covers all sixteen bits, the engine does not read at all. If the fields of a batch name different registers, it raises a warning flag.

The link is modelled as a request/acknowledge port with an arbitrary latency. The engine holds its request until the acknowledge and takes read data in the acknowledge cycle.

Top module: `field_merge_engine`

## Requirements
- R1: After reset `busy`, `done`, `bus_req` and `mismatch` are low.
- R2: A field's mask is `len` ones starting at bit `lo`. Its insert bits are `val` shifted left by `lo` and ANDed with that mask. Value bits beyond the field width, or above bit 15, never reach the register.
- R3: A multi-field write (`req_op` = 0) ORs the masks and bits of its active fields. It performs exactly one read and then one write of `(old & ~mask) | bits`, and register bits outside the mask are kept.
- R4: When the combined mask of a multi-field write is 16'hFFFF, no read is issued. The old word is taken as zero and exactly one write is made.
- R5: `mismatch` is set when any active field other than field 0 names a register different from field 0. Field 0's register is then used for the whole batch. The flag holds its value until the next batch is accepted.
- R6: A multi-field read (`req_op` = 2 or 3) issues exactly one read and no write. Output lane i carries field i of that word for every active field, and lanes of inactive fields are zero.
- R7: A single-field write (`req_op` = 1) uses field 0 only, whatever `req_count` says. It always reads, then writes, and lane 0 returns the field's previous value.
- R8: With zero active fields, `done` pulses in the cycle after acceptance. No bus cycle is issued and `busy` stays low.
- R9: `busy` is high from the cycle after a non-empty batch is accepted up to the cycle in which `done` pulses. A request offered while `busy` is high is ignored.
- R10: `done` is a one-cycle pulse. It coincides with the fall of `busy`, and `rd_fields` and `mismatch` are valid from that cycle.
- R11: `bus_req` stays high with `bus_addr`, `bus_we` and `bus_wdata` unchanged until the cycle in which `bus_ack` is seen.
- R12: A `req_count` above four is treated as four. Field i is active when i is below the effective count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Batch offer, taken when not busy |
| req_op | input | 2 | 0 multi write, 1 single write, 2/3 multi read |
| req_count | input | 3 | Number of active fields (clamped to 4) |
| req_reg | input | 20 | Register index of each field, 5 bits per field, field 0 lowest |
| req_lo | input | 16 | Low bit of each field, 4 bits per field |
| req_len | input | 20 | Bit count of each field, 5 bits per field |
| req_val | input | 64 | New value of each field, 16 bits per field |
| busy | output | 1 | Batch in progress |
| done | output | 1 | Batch complete pulse |
| mismatch | output | 1 | Batch named more than one register |
| rd_fields | output | 64 | Extracted field values, 16 bits per lane |
| bus_req | output | 1 | Link access request |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | 5 | Register index of the access |
| bus_wdata | output | 16 | Write data |
| bus_ack | input | 1 | Access complete |
| bus_rdata | input | 16 | Read data, valid with `bus_ack` |

## Verification
The bench uses the default parameters: four field lanes, 16-bit registers and a 32-entry register space. With four lanes it can exercise the full-cover shortcut with four 4-bit fields and the clamp of an oversized count, and it can place fields whose width or position runs past bit 15. A behavioural model of the register file answers the link with a latency chosen per test, from zero wait cycles to several. This exposes the handshake hold, and it gives room to offer a second batch while one is in flight.

// File: rtl/fme_pkg.sv
package fme_pkg;
  typedef enum logic [1:0] {
    OP_WR_MULTI  = 2'd0,
    OP_WR_SINGLE = 2'd1,
    OP_RD_MULTI  = 2'd2,
    OP_RD_ALT    = 2'd3
  } fme_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } fme_state_e;
endpackage

// File: rtl/fme_field_shaper.sv
module fme_field_shaper #(
  parameter int DATA_W = 16,
  parameter int POS_W  = 4,
  parameter int LEN_W  = 5
) (
  input  logic [POS_W-1:0]  lo,
  input  logic [LEN_W-1:0]  len,
  input  logic [DATA_W-1:0] val,
  output logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] bits
);
  localparam int WIDE_W = 2 * DATA_W;

  logic [WIDE_W-1:0] ones_w;
  logic [WIDE_W-1:0] mask_w;
  logic [WIDE_W-1:0] val_w;

  always_comb begin
    ones_w = ~({WIDE_W{1'b1}} << len);
    mask_w = ones_w << lo;
    val_w  = {{DATA_W{1'b0}}, val} << lo;
    mask   = mask_w[DATA_W-1:0];
    bits   = val_w[DATA_W-1:0] & mask_w[DATA_W-1:0];
  end
endmodule

// File: rtl/fme_field_extract.sv
module fme_field_extract #(
  parameter int DATA_W = 16,
  parameter int POS_W  = 4,
  parameter int LEN_W  = 5
) (
  input  logic [DATA_W-1:0] word,
  input  logic [POS_W-1:0]  lo,
  input  logic [LEN_W-1:0]  len,
  output logic [DATA_W-1:0] field
);
  localparam int WIDE_W = 2 * DATA_W;

  logic [WIDE_W-1:0] shifted;
  logic [WIDE_W-1:0] keep;
  logic [WIDE_W-1:0] picked;

  always_comb begin
    shifted = {{DATA_W{1'b0}}, word} >> lo;
    keep    = ~({WIDE_W{1'b1}} << len);
    picked  = shifted & keep;
    field   = picked[DATA_W-1:0];
  end
endmodule

// File: rtl/fme_seq.sv
module fme_seq
  import fme_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  logic acc_empty,
  input  logic acc_read,
  input  logic lat_write,
  input  logic bus_ack,
  output fme_state_e state,
  output logic finish,
  output logic read_ack
);
  fme_state_e state_n;

  always_comb begin
    state_n  = state;
    finish   = 1'b0;
    read_ack = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (accept) begin
          if (acc_empty)     finish  = 1'b1;
          else if (acc_read) state_n = ST_READ;
          else               state_n = ST_WRITE;
        end
      end
      ST_READ: begin
        if (bus_ack) begin
          read_ack = 1'b1;
          if (lat_write) state_n = ST_WRITE;
          else begin
            state_n = ST_IDLE;
            finish  = 1'b1;
          end
        end
      end
      ST_WRITE: begin
        if (bus_ack) begin
          state_n = ST_IDLE;
          finish  = 1'b1;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= state_n;
  end
endmodule

// File: rtl/field_merge_engine.sv
module field_merge_engine
  import fme_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int REG_W      = 5,
  parameter int MAX_FIELDS = 4,
  parameter int POS_W      = $clog2(DATA_W),
  parameter int LEN_W      = $clog2(DATA_W) + 1,
  parameter int CNT_W      = $clog2(MAX_FIELDS + 1)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           req_valid,
  input  logic [1:0]                     req_op,
  input  logic [CNT_W-1:0]               req_count,
  input  logic [MAX_FIELDS*REG_W-1:0]    req_reg,
  input  logic [MAX_FIELDS*POS_W-1:0]    req_lo,
  input  logic [MAX_FIELDS*LEN_W-1:0]    req_len,
  input  logic [MAX_FIELDS*DATA_W-1:0]   req_val,
  output logic                           busy,
  output logic                           done,
  output logic                           mismatch,
  output logic [MAX_FIELDS*DATA_W-1:0]   rd_fields,
  output logic                           bus_req,
  output logic                           bus_we,
  output logic [REG_W-1:0]               bus_addr,
  output logic [DATA_W-1:0]              bus_wdata,
  input  logic                           bus_ack,
  input  logic [DATA_W-1:0]              bus_rdata
);
  localparam logic [DATA_W-1:0] FULL     = {DATA_W{1'b1}};
  localparam logic [CNT_W-1:0]  CNT_MAX  = CNT_W'(MAX_FIELDS);

  fme_state_e state;
  logic finish, read_ack, accept;
  logic is_read_op, is_single;
  logic [CNT_W-1:0] eff_count;

  logic [DATA_W-1:0] f_mask [MAX_FIELDS];
  logic [DATA_W-1:0] f_bits [MAX_FIELDS];
  logic [DATA_W-1:0] f_out  [MAX_FIELDS];
  logic [MAX_FIELDS-1:0] f_act;
  logic [DATA_W-1:0] all_mask, all_bits;
  logic any_mism, acc_empty, acc_read;

  logic [REG_W-1:0]  reg_q;
  logic [DATA_W-1:0] mask_q, bits_q, word_q;
  logic              write_q;
  logic [MAX_FIELDS-1:0] act_q;
  logic [POS_W-1:0]  lo_q  [MAX_FIELDS];
  logic [LEN_W-1:0]  len_q [MAX_FIELDS];
  logic [DATA_W-1:0] src_word;

  assign is_read_op = req_op[1];
  assign is_single  = (req_op == OP_WR_SINGLE);
  assign accept     = req_valid && (state == ST_IDLE);

  always_comb begin
    if (is_single)                  eff_count = CNT_W'(1);
    else if (req_count > CNT_MAX)   eff_count = CNT_MAX;
    else                            eff_count = req_count;
  end

  genvar gi;
  generate
    for (gi = 0; gi < MAX_FIELDS; gi++) begin : g_lane
      assign f_act[gi] = (CNT_W'(gi) < eff_count);

      fme_field_shaper #(.DATA_W(DATA_W), .POS_W(POS_W), .LEN_W(LEN_W)) u_shape (
        .lo   (req_lo [gi*POS_W  +: POS_W]),
        .len  (req_len[gi*LEN_W  +: LEN_W]),
        .val  (req_val[gi*DATA_W +: DATA_W]),
        .mask (f_mask[gi]),
        .bits (f_bits[gi])
      );

      fme_field_extract #(.DATA_W(DATA_W), .POS_W(POS_W), .LEN_W(LEN_W)) u_pick (
        .word  (src_word),
        .lo    (lo_q[gi]),
        .len   (len_q[gi]),
        .field (f_out[gi])
      );

      always_ff @(posedge clk) begin
        if (rst) begin
          lo_q[gi]  <= '0;
          len_q[gi] <= '0;
          rd_fields[gi*DATA_W +: DATA_W] <= '0;
        end else begin
          if (accept) begin
            lo_q[gi]  <= req_lo [gi*POS_W +: POS_W];
            len_q[gi] <= req_len[gi*LEN_W +: LEN_W];
          end
          if (finish) begin
            if (state != ST_IDLE && act_q[gi])
              rd_fields[gi*DATA_W +: DATA_W] <= f_out[gi];
            else
              rd_fields[gi*DATA_W +: DATA_W] <= '0;
          end
        end
      end
    end
  endgenerate

  always_comb begin
    all_mask = '0;
    all_bits = '0;
    any_mism = 1'b0;
    for (int i = 0; i < MAX_FIELDS; i++) begin
      if (f_act[i]) begin
        all_mask = all_mask | f_mask[i];
        all_bits = all_bits | f_bits[i];
        if (i > 0 && req_reg[i*REG_W +: REG_W] != req_reg[REG_W-1:0])
          any_mism = 1'b1;
      end
    end
  end

  assign acc_empty = (eff_count == '0);
  assign acc_read  = is_read_op || is_single || (all_mask != FULL);

  fme_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .acc_empty (acc_empty),
    .acc_read  (acc_read),
    .lat_write (write_q),
    .bus_ack   (bus_ack),
    .state     (state),
    .finish    (finish),
    .read_ack  (read_ack)
  );

  assign src_word = (state == ST_READ) ? bus_rdata : word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q    <= '0;
      mask_q   <= '0;
      bits_q   <= '0;
      word_q   <= '0;
      write_q  <= 1'b0;
      act_q    <= '0;
      mismatch <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= finish;
      if (accept) begin
        reg_q    <= req_reg[REG_W-1:0];
        mask_q   <= all_mask;
        bits_q   <= all_bits;
        word_q   <= '0;
        write_q  <= !is_read_op;
        act_q    <= f_act;
        mismatch <= any_mism;
      end else if (read_ack) begin
        word_q <= bus_rdata;
      end
    end
  end

  assign busy      = (state != ST_IDLE);
  assign bus_req   = (state == ST_READ) || (state == ST_WRITE);
  assign bus_we    = (state == ST_WRITE);
  assign bus_addr  = reg_q;
  assign bus_wdata = (word_q & ~mask_q) | bits_q;
endmodule

// File: rtl/fme_checker.sv
module fme_checker #(
  parameter int DATA_W = 16,
  parameter int REG_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              bus_req,
  input logic              bus_we,
  input logic [REG_W-1:0]  bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_ack
);
  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  busy_fall_done_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R9
  idle_no_bus_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !bus_req);

  // R8
  done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

bind field_merge_engine fme_checker #(.DATA_W(DATA_W), .REG_W(REG_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .done      (done),
  .bus_req   (bus_req),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_ack   (bus_ack)
);

// File: tb/field_merge_engine_tb.sv
module field_merge_engine_tb;
  localparam int DW = 16, RW = 5, NF = 4, PW = 4, LW = 5, CW = 3;

  logic clk = 0, rst = 1;
  logic req_valid = 0;
  logic [1:0] req_op = 0;
  logic [CW-1:0] req_count = 0;
  logic [NF*RW-1:0] req_reg = 0;
  logic [NF*PW-1:0] req_lo = 0;
  logic [NF*LW-1:0] req_len = 0;
  logic [NF*DW-1:0] req_val = 0;
  logic busy, done, mismatch, bus_req, bus_we;
  logic [NF*DW-1:0] rd_fields;
  logic [RW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic bus_ack = 0;
  logic [DW-1:0] bus_rdata = 0;

  always #2 clk = ~clk;

  field_merge_engine u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_count(req_count),
    .req_reg(req_reg), .req_lo(req_lo), .req_len(req_len), .req_val(req_val),
    .busy(busy), .done(done), .mismatch(mismatch), .rd_fields(rd_fields),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  int checks = 0, failures = 0, cycles = 0;
  int lat = 0, n_rd = 0, n_wr = 0, wait_cnt = 0;
  logic [DW-1:0] mem [32];
  int f_reg [NF], f_lo [NF], f_len [NF], f_val [NF];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // register file model answering the link
  initial forever begin
    @(negedge clk);
    bus_ack = 0;
    if (bus_req) begin
      if (wait_cnt >= lat) begin
        bus_ack = 1;
        wait_cnt = 0;
        if (bus_we) begin mem[bus_addr] = bus_wdata; n_wr++; end
        else begin bus_rdata = mem[bus_addr]; n_rd++; end
      end else wait_cnt++;
    end
  end

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  function automatic int fmask(int lo, int len);
    return (((1 << len) - 1) << lo) & 'hFFFF;
  endfunction

  function automatic int fget(int w, int lo, int len);
    return (w >> lo) & ((1 << len) - 1);
  endfunction

  task automatic run(input int op, input int cnt, input int inject, input string tag);
    int nf, msk, bts, mism, old_w, new_w, exp_rd, exp_wr, r0, cyc, keep31;
    bit seen;
    nf = (op == 1) ? 1 : ((cnt > NF) ? NF : cnt);
    r0 = f_reg[0];
    msk = 0; bts = 0; mism = 0;
    for (int i = 0; i < nf; i++) begin
      msk |= fmask(f_lo[i], f_len[i]);
      bts |= (f_val[i] << f_lo[i]) & fmask(f_lo[i], f_len[i]);
      if (i > 0 && f_reg[i] != r0) mism = 1;
    end
    if (nf == 0) begin exp_rd = 0; exp_wr = 0; end
    else if (op >= 2) begin exp_rd = 1; exp_wr = 0; end
    else begin exp_rd = (op == 1 || msk != 'hFFFF) ? 1 : 0; exp_wr = 1; end
    old_w = exp_rd ? int'(mem[r0]) : 0;
    new_w = exp_wr ? (((old_w & ~msk) | bts) & 'hFFFF) : int'(mem[r0]);
    keep31 = mem[31];
    n_rd = 0; n_wr = 0;
    @(negedge clk);
    req_valid = 1; req_op = op[1:0]; req_count = cnt[CW-1:0];
    for (int i = 0; i < NF; i++) begin
      req_reg[i*RW +: RW] = f_reg[i][RW-1:0];
      req_lo [i*PW +: PW] = f_lo[i][PW-1:0];
      req_len[i*LW +: LW] = f_len[i][LW-1:0];
      req_val[i*DW +: DW] = f_val[i][DW-1:0];
    end
    @(negedge clk);
    req_valid = 0;
    seen = 0;
    for (cyc = 0; cyc < 300; cyc++) begin
      if (done) begin seen = 1; break; end
      // R9: busy must be up every cycle until done
      if (busy !== 1'b1) chk(0, {tag, " R9 busy"}, busy, 1);
      if (inject && cyc == 1) begin
        req_valid = 1; req_op = 0; req_count = 1;
        req_reg[RW-1:0] = 31; req_lo[PW-1:0] = 0; req_len[LW-1:0] = 16;
        req_val[DW-1:0] = 16'h5A5A;
      end
      if (inject && cyc == 2) req_valid = 0;
      @(negedge clk);
    end
    chk(seen, {tag, " R10 done seen"}, seen, 1);
    chk(busy == 0, {tag, " R10 busy low at done"}, busy, 0);
    chk(n_rd == exp_rd, {tag, " read count"}, n_rd, exp_rd);
    chk(n_wr == exp_wr, {tag, " write count"}, n_wr, exp_wr);
    chk(int'(mem[r0]) == new_w, {tag, " register value"}, mem[r0], new_w);
    chk(int'(mismatch) == mism, {tag, " R5 flag"}, mismatch, mism);
    for (int i = 0; i < NF; i++) begin
      int e;
      e = (i < nf) ? fget(old_w, f_lo[i], f_len[i]) : 0;
      if (op == 0) e = (i < nf) ? fget(old_w, f_lo[i], f_len[i]) : 0;
      chk(int'(rd_fields[i*DW +: DW]) == e, {tag, " lane"}, rd_fields[i*DW +: DW], e);
    end
    if (inject) chk(int'(mem[31]) == keep31, {tag, " R9 ignored request"}, mem[31], keep31);
    @(negedge clk);
    chk(done == 0, {tag, " R10 single pulse"}, done, 0);
  endtask

  task automatic setf(input int i, input int r, input int lo, input int len, input int v);
    f_reg[i] = r; f_lo[i] = lo; f_len[i] = len; f_val[i] = v;
  endtask

  initial begin
    for (int a = 0; a < 32; a++) mem[a] = 16'(a * 16'h1357 + 16'h0F0F);
    for (int i = 0; i < NF; i++) setf(i, 0, 0, 1, 0);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy == 0 && done == 0 && bus_req == 0 && mismatch == 0, "R1 reset outputs",
        {busy, done, bus_req, mismatch}, 0);
    rst = 0;

    // R3: two fields, untouched bits kept
    lat = 3;
    setf(0, 3, 0, 5, 'h15); setf(1, 3, 8, 5, 'h0A);
    run(0, 2, 0, "R3 merge");

    // R2: excess value bits and bits above 15 dropped
    lat = 1;
    setf(0, 4, 13, 3, 'hFF); setf(1, 4, 14, 4, 'hF); setf(2, 4, 2, 2, 'h7);
    run(0, 3, 0, "R2 trim");

    // R4: four 4-bit fields cover all bits, no read
    lat = 0;
    setf(0, 7, 0, 4, 1); setf(1, 7, 4, 4, 2); setf(2, 7, 8, 4, 3); setf(3, 7, 12, 4, 4);
    run(0, 4, 0, "R4 full cover");
    setf(0, 8, 0, 16, 'hBEEF);
    run(0, 1, 0, "R4 single wide field");

    // R5: mixed registers, first used; next batch clears flag
    lat = 2;
    setf(0, 5, 0, 4, 9); setf(1, 6, 4, 4, 3);
    run(0, 2, 0, "R5 mixed");
    setf(1, 5, 4, 4, 3);
    run(0, 2, 0, "R5 cleared");

    // R6: multi read, lane 3 inactive
    lat = 5;
    setf(0, 10, 0, 3, 0); setf(1, 10, 5, 6, 0); setf(2, 10, 12, 4, 0); setf(3, 10, 1, 1, 0);
    run(2, 3, 0, "R6 read");

    // R12: count above four clamps, op code 3 reads too
    run(3, 7, 0, "R12 clamp");

    // R7: single write uses field 0 only, returns old value
    lat = 1;
    setf(0, 12, 4, 6, 'h2A); setf(1, 12, 0, 4, 'hF); setf(2, 13, 0, 4, 'hF);
    run(1, 3, 0, "R7 single");

    // R8: empty batch
    run(0, 0, 0, "R8 empty");

    // R9: request offered while busy is ignored
    lat = 4;
    setf(0, 14, 2, 5, 'h11);
    run(0, 1, 1, "R9 inject");

    // R11: zero-latency read then write
    lat = 0;
    setf(0, 15, 3, 7, 'h55);
    run(0, 1, 0, "R11 fast link");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule